// File: doc/BRIEF.md
# PCI Configuration Command and Status Word

This block keeps the Command and Status halves of the configuration dword at header offset 04h for a PCI target. The bus side writes it through a 32-bit data port qualified by four byte enables. Command occupies bits 15:0 and Status occupies bits 31:16. The read view is combinational from the stored state, so a value written at one clock edge can be read back during the next cycle. A second, narrow loader port is used once at power-up by the serial configuration memory to set the capabilities-list flag. The bus can never change that flag.

The target logic reports three kinds of event, each as a one-cycle pulse:
- it signaled a target abort;
- it asserted the system-error line;
- it detected a parity error, either in an address phase or in a write data phase.

The block latches each event into a sticky status flag, which software clears by writing 1 to it. The block drives the I/O decode enable, the memory decode enable, the parity response enable and the system-error driver enable for the rest of the target. Every other bit is hardwired, unsupported or reserved, and has a fixed read value.

Top module: `pcs_cmdstat`

## Requirements
- R1: After reset, `cfg_rdata` reads 32'h0280_0000, and the four enable outputs are 0.
- R2: Command bits 0 (I/O enable), 1 (memory enable), 6 (parity response) and 8 (system-error driver enable) take the written value at the clock edge of a qualified write. The outputs `io_en`, `mem_en` and `perr_resp_en` follow bits 0, 1 and 6.
- R3: Command bits 2, 3, 4, 5, 7, 9 and 15:10 always read 0, whatever is written to them.
- R4: `cfg_be[k]` gates writes to `cfg_wdata[8k+7:8k]`. Byte 0 is command 7:0, byte 1 is command 15:8, byte 2 is status 7:0 and byte 3 is status 15:8. A byte whose enable is 0 is left unchanged.
- R5: Status bit 4 (read bit 20) takes `ee_cap` when `ee_ld` is high. Bus writes never change it.
- R6: Status bit 7 reads 1, and status bits 10:9 read 01. Status bits 3:0, 6:5, 8, 12 and 13 read 0.
- R7: Status bit 11 sets on `ev_tgt_abort`, and status bit 14 sets on `ev_serr`. A write of 1 to read bit 27 or read bit 30 clears the corresponding flag, and a write of 0 leaves it unchanged.
- R8: Status bit 15 sets on `ev_perr_addr` or `ev_perr_wdata` whether command bit 6 is 0 or 1. A write of 1 to read bit 31 clears it.
- R9: When an event and a write-one-to-clear reach the same status flag in the same cycle, the flag ends up set.
- R10: `serr_drv_en` is high exactly when command bits 8 and 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe for the dword |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data: {status, command} |
| cfg_rdata | output | 32 | Read view: {status, command} |
| ee_ld | input | 1 | Loader strobe from the serial configuration memory |
| ee_cap | input | 1 | Capabilities-list flag value to load |
| ev_tgt_abort | input | 1 | Pulse: target abort was signaled |
| ev_serr | input | 1 | Pulse: the system-error line was asserted |
| ev_perr_addr | input | 1 | Pulse: parity error in an address phase |
| ev_perr_wdata | input | 1 | Pulse: parity error in a write data phase as target |
| io_en | output | 1 | I/O space decode enable |
| mem_en | output | 1 | Memory space decode enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_drv_en | output | 1 | System-error driver enable |

## Verification
The assertions check on every cycle that:
- fixed command and status bits hold their read values;
- an event pulse always leaves its flag set on the next cycle, even with a colliding clear;
- a lone clear always clears its flag;
- the capabilities flag moves only on a loader strobe;
- the driver enable is never high without parity response.

Only the bench's scenarios show that byte-enable gating is correct across all four lanes, that a write of 0 to a sticky flag leaves it alone, and that the read view matches a whole sequence of writes, loads and events.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   localparam int CFG_W   = 32;
   localparam int HALF_W  = CFG_W / 2;
   localparam int NBYTE   = CFG_W / 8;
   // command bit positions
   localparam int C_IO    = 0;
   localparam int C_MEM   = 1;
   localparam int C_PERR  = 6;
   localparam int C_SERR  = 8;
   // status bit positions
   localparam int S_CAP   = 4;
   localparam int S_FBB   = 7;
   localparam int S_DEVLO = 9;
   localparam int S_TABT  = 11;
   localparam int S_SSE   = 14;
   localparam int S_DPE   = 15;

   typedef struct packed {
      logic tgt_abort;
      logic serr;
      logic perr;
   } pcs_evt_t;
endpackage

// File: rtl/pcs_sticky_bit.sv
module pcs_sticky_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)      q_o <= 1'b0;
            else if (set_i)  q_o <= 1'b1;
            else if (clr_i)  q_o <= 1'b0;
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)      q_o <= 1'b0;
            else if (clr_i)  q_o <= 1'b0;
            else if (set_i)  q_o <= 1'b1;
      end
   endgenerate

   // R9: a set in the same cycle as a clear is not lost
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_WINS && set_i) |=> q_o);
   // R7: a clear without a set empties the flag
   p_clr_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/pcs_cmd_reg.sv
module pcs_cmd_reg
   import pcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        be_i,
   input  logic [HALF_W-1:0] wd_i,
   output logic [HALF_W-1:0] cmd_o
);
   logic io_q, mem_q, perr_q, serr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_q   <= 1'b0;
         mem_q  <= 1'b0;
         perr_q <= 1'b0;
         serr_q <= 1'b0;
      end else if (wr_i) begin
         if (be_i[0]) begin
            io_q   <= wd_i[C_IO];
            mem_q  <= wd_i[C_MEM];
            perr_q <= wd_i[C_PERR];
         end
         if (be_i[1]) serr_q <= wd_i[C_SERR];
      end
   end

   always_comb begin
      cmd_o         = '0;
      cmd_o[C_IO]   = io_q;
      cmd_o[C_MEM]  = mem_q;
      cmd_o[C_PERR] = perr_q;
      cmd_o[C_SERR] = serr_q;
   end

   // R3: unsupported, hardwired and reserved command bits stay zero
   p_cmd_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o[15:9] == '0) && !cmd_o[7] && (cmd_o[5:2] == '0));
   // R2: a byte-0 write lands in the enables
   p_cmd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && be_i[0]) |=> (cmd_o[C_MEM] == $past(wd_i[C_MEM])));
   // R4: without a byte-1 enable, the driver enable bit holds
   p_cmd_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && be_i[1]) |=> $stable(cmd_o[C_SERR]));
endmodule

// File: rtl/pcs_sts_reg.sv
module pcs_sts_reg
   import pcs_pkg::*;
#(
   parameter bit       CAP_RST       = 1'b0,
   parameter bit [1:0] DEVSEL_TIMING = 2'b01,
   parameter bit       SET_WINS      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        be_i,
   input  logic [HALF_W-1:0] wd_i,
   input  logic              ee_ld_i,
   input  logic              ee_cap_i,
   input  pcs_evt_t          evt_i,
   output logic [HALF_W-1:0] sts_o
);
   localparam int NSTK = 3;
   localparam int STK_POS [NSTK] = '{S_TABT, S_SSE, S_DPE};

   logic            cap_q;
   logic [NSTK-1:0] stk_set, stk_q;
   logic            hi_wr;

   initial begin : elab_chk
      assert (DEVSEL_TIMING != 2'b11) else $error("DEVSEL_TIMING 11 is reserved");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cap_q <= CAP_RST;
      else if (ee_ld_i) cap_q <= ee_cap_i;

   assign hi_wr   = wr_i & be_i[1];
   assign stk_set = {evt_i.perr, evt_i.serr, evt_i.tgt_abort};

   for (genvar i = 0; i < NSTK; i++) begin : g_stk
      pcs_sticky_bit #(.SET_WINS(SET_WINS)) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (stk_set[i]),
         .clr_i (hi_wr & wd_i[STK_POS[i]]),
         .q_o   (stk_q[i])
      );
   end

   always_comb begin
      sts_o                       = '0;
      sts_o[S_CAP]                = cap_q;
      sts_o[S_FBB]                = 1'b1;
      sts_o[S_DEVLO+1:S_DEVLO]    = DEVSEL_TIMING;
      for (int i = 0; i < NSTK; i++) sts_o[STK_POS[i]] = stk_q[i];
   end

   // R5: capabilities flag moves only under the loader strobe
   p_cap_only_ee_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_ld_i |=> $stable(sts_o[S_CAP]));
   // R8: any parity event leaves the detect flag set
   p_dpe_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.perr |=> sts_o[S_DPE]);
   // R6: hardwired and reserved status bits keep their values
   p_sts_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sts_o[S_FBB] && (sts_o[10:9] == DEVSEL_TIMING) && (sts_o[13:12] == '0)
      && !sts_o[8] && (sts_o[6:5] == '0) && (sts_o[3:0] == '0));
endmodule

// File: rtl/pcs_cmdstat.sv
module pcs_cmdstat
   import pcs_pkg::*;
#(
   parameter bit       CAP_RST       = 1'b0,
   parameter bit [1:0] DEVSEL_TIMING = 2'b01,
   parameter bit       SET_WINS      = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        ee_ld,
   input  logic        ee_cap,
   input  logic        ev_tgt_abort,
   input  logic        ev_serr,
   input  logic        ev_perr_addr,
   input  logic        ev_perr_wdata,
   output logic        io_en,
   output logic        mem_en,
   output logic        perr_resp_en,
   output logic        serr_drv_en
);
   logic [HALF_W-1:0] cmd, sts;
   pcs_evt_t          evt;

   assign evt.tgt_abort = ev_tgt_abort;
   assign evt.serr      = ev_serr;
   assign evt.perr      = ev_perr_addr | ev_perr_wdata;

   pcs_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (cfg_wr),
      .be_i  (cfg_be[1:0]),
      .wd_i  (cfg_wdata[HALF_W-1:0]),
      .cmd_o (cmd)
   );

   pcs_sts_reg #(
      .CAP_RST       (CAP_RST),
      .DEVSEL_TIMING (DEVSEL_TIMING),
      .SET_WINS      (SET_WINS)
   ) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cfg_wr),
      .be_i     (cfg_be[NBYTE-1:2]),
      .wd_i     (cfg_wdata[CFG_W-1:HALF_W]),
      .ee_ld_i  (ee_ld),
      .ee_cap_i (ee_cap),
      .evt_i    (evt),
      .sts_o    (sts)
   );

   assign cfg_rdata    = {sts, cmd};
   assign io_en        = cmd[C_IO];
   assign mem_en       = cmd[C_MEM];
   assign perr_resp_en = cmd[C_PERR];
   assign serr_drv_en  = cmd[C_SERR] & cmd[C_PERR];

   // R10: driver enable requires parity response
   p_serr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      serr_drv_en |-> perr_resp_en);
   // R7: a signaled-abort pulse is always recorded
   p_tabt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tgt_abort |=> cfg_rdata[16+S_TABT]);
endmodule

// File: tb/pcs_cmdstat_bench.sv
module pcs_cmdstat_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        ee_ld = 1'b0, ee_cap = 1'b0;
   logic        ev_tgt_abort = 1'b0, ev_serr = 1'b0;
   logic        ev_perr_addr = 1'b0, ev_perr_wdata = 1'b0;
   logic        io_en, mem_en, perr_resp_en, serr_drv_en;

   int n_cmp = 0, n_bad = 0;

   // model state
   logic m_io = 0, m_mem = 0, m_perr = 0, m_serr = 0, m_cap = 0;
   logic m_tabt = 0, m_sse = 0, m_dpe = 0;

   always #10 clk = ~clk;   // 50 MHz

   pcs_cmdstat u_pcs_cmdstat (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ee_ld(ee_ld),
      .ee_cap(ee_cap), .ev_tgt_abort(ev_tgt_abort), .ev_serr(ev_serr),
      .ev_perr_addr(ev_perr_addr), .ev_perr_wdata(ev_perr_wdata),
      .io_en(io_en), .mem_en(mem_en), .perr_resp_en(perr_resp_en),
      .serr_drv_en(serr_drv_en)
   );

   function automatic logic [31:0] exp_rd();
      logic [31:0] r = '0;
      r[0] = m_io;  r[1] = m_mem;  r[6] = m_perr;  r[8] = m_serr;
      r[20] = m_cap; r[23] = 1'b1; r[26:25] = 2'b01;
      r[27] = m_tabt; r[30] = m_sse; r[31] = m_dpe;
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, cfg_rdata, exp_rd());
      chk("R2 io_en", {31'b0, io_en}, {31'b0, m_io});
      chk("R2 mem_en", {31'b0, mem_en}, {31'b0, m_mem});
      chk("R2 perr_resp_en", {31'b0, perr_resp_en}, {31'b0, m_perr});
      chk("R10 serr_drv_en", {31'b0, serr_drv_en}, {31'b0, m_serr & m_perr});
   endtask

   // drive one cycle at negedge, update model, compare at next negedge
   task automatic step(input logic wr, input logic [3:0] be, input logic [31:0] wd,
                       input logic ld, input logic cv, input logic ta,
                       input logic se, input logic pa, input logic pw,
                       input string req);
      cfg_wr = wr; cfg_be = be; cfg_wdata = wd; ee_ld = ld; ee_cap = cv;
      ev_tgt_abort = ta; ev_serr = se; ev_perr_addr = pa; ev_perr_wdata = pw;
      if (wr && be[0]) begin m_io = wd[0]; m_mem = wd[1]; m_perr = wd[6]; end
      if (wr && be[1]) m_serr = wd[8];
      m_tabt = ta | (m_tabt & !(wr && be[3] && wd[27]));
      m_sse  = se | (m_sse  & !(wr && be[3] && wd[30]));
      m_dpe  = pa | pw | (m_dpe & !(wr && be[3] && wd[31]));
      if (ld) m_cap = cv;
      @(negedge clk);
      cfg_wr = 0; ee_ld = 0; ev_tgt_abort = 0; ev_serr = 0;
      ev_perr_addr = 0; ev_perr_wdata = 0;
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      chk("R1 reset value", cfg_rdata, 32'h0280_0000);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 / R3: all ones to command, unsupported bits must stay 0
      step(1, 4'b0011, 32'h0000_FFFF, 0, 0, 0, 0, 0, 0, "R3 cmd fixed bits");
      chk("R2 cmd rw", cfg_rdata[15:0], 16'h0143);
      // R4: only byte 1 enabled, byte-0 bits hold
      step(1, 4'b0010, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R4 byte lanes");
      chk("R4 byte0 held", cfg_rdata[7:0], 8'h43);
      chk("R10 serr off", {31'b0, serr_drv_en}, 32'd0);
      // R5: bus write to cap ignored, loader sets it
      step(1, 4'b1111, 32'hFFFF_0000, 0, 0, 0, 0, 0, 0, "R6 status fixed");
      chk("R5 cap bus ignored", {31'b0, cfg_rdata[20]}, 32'd0);
      step(0, 4'b0000, 32'h0, 1, 1, 0, 0, 0, 0, "R5 ee load");
      chk("R5 cap loaded", {31'b0, cfg_rdata[20]}, 32'd1);
      // R8: parity with response disabled
      step(1, 4'b0011, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R2 cmd clear");
      step(0, 4'b0000, 32'h0, 0, 0, 0, 0, 0, 1, "R8 dpe set resp off");
      chk("R8 dpe", {31'b0, cfg_rdata[31]}, 32'd1);
      step(0, 4'b0000, 32'h0, 0, 0, 1, 1, 0, 0, "R7 events");
      // R7: write 0 leaves flags
      step(1, 4'b1000, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R7 write0 keep");
      chk("R7 flags kept", {29'b0, cfg_rdata[31:30], cfg_rdata[27]}, 32'd7);
      // R9: clear and set in same cycle
      step(1, 4'b1000, 32'hC800_0000, 0, 0, 1, 0, 1, 0, "R9 set wins");
      chk("R9 tabt kept", {31'b0, cfg_rdata[27]}, 32'd1);
      chk("R7 sse cleared", {31'b0, cfg_rdata[30]}, 32'd0);
      // R10: both bits on
      step(1, 4'b0011, 32'h0000_0140, 0, 0, 0, 0, 0, 0, "R10 serr on");
      chk("R10 serr on", {31'b0, serr_drv_en}, 32'd1);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         step($urandom % 2, 4'($urandom), $urandom, ($urandom % 16) == 0,
              $urandom % 2, ($urandom % 8) == 0, ($urandom % 8) == 0,
              ($urandom % 10) == 0, ($urandom % 10) == 0, "R2-random");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule